// File: doc/BRIEF.md
# Conversion Set Sequencer with Power-Mode Control

This block decides when a three-axis magnetic sensor with a temperature channel runs a conversion set, and in which order the channels in that set are measured. Configuration arrives as plain input fields: power mode, trigger source, channel-selection code, temperature enable, averaging code and nap-interval code. The block sends one start request per channel to a converter, together with the channel number and the number of samples to average. It then waits for that channel's done strobe before it moves on to the next channel.

There are four power modes. Standby runs one set per accepted trigger. Sleep runs nothing. Continuous starts a new set right after the previous one ends. Wake-and-nap runs a set, idles for a coded number of milliseconds, and repeats. The millisecond timebase is a parameterised clock prescaler. After each set the block advances a rolling 3-bit set counter, raises a result-ready flag and emits a one-cycle set-complete pulse. A trigger that arrives while a set is running is dropped, and the running set always finishes.

Top module: `sense_seq_top`

## Requirements
- R1: After reset, `conv_start`, `set_done`, `result_ready` and `busy` are 0 and `set_count` is 0.
- R2: Channel numbers on `conv_chan` are 0 = temperature, 1 = X, 2 = Y, 3 = Z. When `temp_en` is 1 the temperature channel comes first. The magnetic channels follow in this order for `chan_code` values: 1 X; 2 Y; 3 X,Y; 4 Z; 5 Z,X; 6 Y,Z; 7 X,Y,Z; 8 X,Y,X; 9 Y,X,Y; A Y,Z,Y; B X,Z,X.
- R3: `chan_code` 0 and the reserved values C to F select no magnetic channel. A set with no channel at all issues no `conv_start` and raises `set_done` two cycles after the trigger cycle.
- R4: In standby (`pwr_mode` 0) a set starts on `host_go` when `trig_sel` is 0, and on a rising edge of `ext_trig` when `trig_sel` is 1. The source that is not selected has no effect, and a steady high level on `ext_trig` does not retrigger. The first `conv_start` appears in the cycle after the accepted trigger.
- R5: Triggers that arrive while a set is running are dropped, not queued. Exactly one set results.
- R6: In sleep mode (`pwr_mode` 1) no set starts and no `conv_start` is issued. A set already running when the mode changes still finishes.
- R7: In continuous mode (`pwr_mode` 2) the next set's first `conv_start` appears in the cycle after `set_done`.
- R8: In wake-and-nap mode (`pwr_mode` 3) the first set starts at once. After each set the block naps. The nap length in milliseconds comes from `nap_code`: 0→1, 1→5, 2→10, 3→15, 4→20, 5→30, 6→50, 7→100, 8→500, 9→1000, A→2000, B→5000, C→20000, and D to F also give 20000. The next `conv_start` comes N*TICKS_PER_MS+1 cycles after the `set_done` cycle.
- R9: `set_count` increments by one when each set completes and wraps from 7 to 0.
- R10: `result_ready` rises together with `set_done`. It clears when a new set starts or one cycle after `rd_ack`. If completion and `rd_ack` fall in the same cycle, completion wins.
- R11: `conv_samples` is 2^`avg_code` for codes 0 to 5, and 32 for codes 6 and 7.
- R12: `set_done` is a single-cycle pulse, and `conv_start` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_mode | input | 2 | 0 standby, 1 sleep, 2 continuous, 3 wake-and-nap |
| trig_sel | input | 1 | Standby trigger source: 0 host strobe, 1 external pin edge |
| chan_code | input | 4 | Magnetic channel selection and order code |
| temp_en | input | 1 | Include the temperature channel in each set |
| avg_code | input | 3 | Averaging code |
| nap_code | input | 4 | Nap interval code for wake-and-nap |
| host_go | input | 1 | Host trigger strobe |
| ext_trig | input | 1 | External trigger pin, rising edge active |
| conv_done | input | 1 | Converter done strobe for the current channel |
| rd_ack | input | 1 | Host acknowledge of read results |
| conv_start | output | 1 | Start request for one channel conversion |
| conv_chan | output | 2 | Channel number for the start request |
| conv_samples | output | 6 | Samples per channel for the converter |
| busy | output | 1 | A set is in progress |
| set_count | output | 3 | Rolling completed-set counter |
| result_ready | output | 1 | A full set has completed |
| set_done | output | 1 | One-cycle set-complete pulse |

## Verification
The hardest case to reach from the ports is a trigger landing inside a running set. Dropping it leaves no trace, so the only evidence is how many sets and start requests happen afterwards. The bench uses a long averaging code, which makes the converter stub slow. It then pulses `host_go` several times while `busy` is high, and afterwards counts both the `set_done` pulses and the `conv_start` requests. A second hard case is the race between completion and `rd_ack`. The bench reaches it with an empty set, because that set completes a fixed two cycles after its trigger, so the acknowledge can be placed in exactly the completing cycle.

// File: rtl/sense_seq_pkg.sv
package sense_seq_pkg;

  localparam int MS_W = 15;

  localparam logic [1:0] MODE_STBY  = 2'd0;
  localparam logic [1:0] MODE_SLEEP = 2'd1;
  localparam logic [1:0] MODE_CONT  = 2'd2;
  localparam logic [1:0] MODE_NAP   = 2'd3;

  localparam logic [1:0] CH_T = 2'd0;
  localparam logic [1:0] CH_X = 2'd1;
  localparam logic [1:0] CH_Y = 2'd2;
  localparam logic [1:0] CH_Z = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_WAIT = 2'd2,
    ST_NAP  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [2:0]       n;
    logic [3:0][1:0]  ch;
  } plan_t;

  // Channel plan for one set: temperature first, then magnetic order.
  function automatic plan_t plan_of(input logic [3:0] code, input logic t_en);
    plan_t p;
    logic [2:0][1:0] m;
    int mn;
    int base;
    m  = '0;
    mn = 0;
    case (code)
      4'h1: begin m[0] = CH_X; mn = 1; end
      4'h2: begin m[0] = CH_Y; mn = 1; end
      4'h3: begin m[0] = CH_X; m[1] = CH_Y; mn = 2; end
      4'h4: begin m[0] = CH_Z; mn = 1; end
      4'h5: begin m[0] = CH_Z; m[1] = CH_X; mn = 2; end
      4'h6: begin m[0] = CH_Y; m[1] = CH_Z; mn = 2; end
      4'h7: begin m[0] = CH_X; m[1] = CH_Y; m[2] = CH_Z; mn = 3; end
      4'h8: begin m[0] = CH_X; m[1] = CH_Y; m[2] = CH_X; mn = 3; end
      4'h9: begin m[0] = CH_Y; m[1] = CH_X; m[2] = CH_Y; mn = 3; end
      4'hA: begin m[0] = CH_Y; m[1] = CH_Z; m[2] = CH_Y; mn = 3; end
      4'hB: begin m[0] = CH_X; m[1] = CH_Z; m[2] = CH_X; mn = 3; end
      default: mn = 0;
    endcase
    p = '0;
    base = t_en ? 1 : 0;
    if (t_en) p.ch[0] = CH_T;
    for (int i = 0; i < 3; i++) begin
      if (i < mn) p.ch[i + base] = m[i];
    end
    p.n = 3'(mn + base);
    return p;
  endfunction

  function automatic logic [MS_W-1:0] nap_ms(input logic [3:0] code);
    case (code)
      4'h0: return MS_W'(1);
      4'h1: return MS_W'(5);
      4'h2: return MS_W'(10);
      4'h3: return MS_W'(15);
      4'h4: return MS_W'(20);
      4'h5: return MS_W'(30);
      4'h6: return MS_W'(50);
      4'h7: return MS_W'(100);
      4'h8: return MS_W'(500);
      4'h9: return MS_W'(1000);
      4'hA: return MS_W'(2000);
      4'hB: return MS_W'(5000);
      default: return MS_W'(20000);
    endcase
  endfunction

  function automatic logic [5:0] samples_of(input logic [2:0] code);
    if (code > 3'd5) return 6'd32;
    return 6'(1 << code);
  endfunction

endpackage

// File: rtl/sense_seq_trigger.sv
module sense_seq_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_sel,
  input  logic host_go,
  input  logic ext_trig,
  output logic trig_evt
);
  logic ext_q;
  logic ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;
  end

  assign ext_rise = ext_trig & ~ext_q;
  assign trig_evt = trig_sel ? ext_rise : host_go;
endmodule

// File: rtl/sense_seq_nap_timer.sv
module sense_seq_nap_timer #(
  parameter int TICKS_PER_MS = 1000,
  parameter int MS_W         = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MS_W-1:0] ms_val,
  input  logic            run,
  output logic            expire
);
  localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICKS_PER_MS - 1);

  logic [PW-1:0]   presc;
  logic [MS_W-1:0] ms_left;
  logic            ms_tick;

  assign ms_tick = run && (presc == PLAST);
  assign expire  = ms_tick && (ms_left == MS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc   <= '0;
      ms_left <= '0;
    end else if (load) begin
      presc   <= '0;
      ms_left <= ms_val;
    end else if (run) begin
      if (ms_tick) begin
        presc   <= '0;
        ms_left <= ms_left - MS_W'(1);
      end else begin
        presc <= presc + PW'(1);
      end
    end
  end
endmodule

// File: rtl/sense_seq_top.sv
module sense_seq_top
  import sense_seq_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int SET_CNT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pwr_mode,
  input  logic                 trig_sel,
  input  logic [3:0]           chan_code,
  input  logic                 temp_en,
  input  logic [2:0]           avg_code,
  input  logic [3:0]           nap_code,
  input  logic                 host_go,
  input  logic                 ext_trig,
  input  logic                 conv_done,
  input  logic                 rd_ack,
  output logic                 conv_start,
  output logic [1:0]           conv_chan,
  output logic [5:0]           conv_samples,
  output logic                 busy,
  output logic [SET_CNT_W-1:0] set_count,
  output logic                 result_ready,
  output logic                 set_done
);
  seq_state_e state;
  plan_t      plan_q;
  plan_t      plan_now;
  logic [2:0] idx;
  logic       set_done_q;

  // Named internal events for the checker
  logic trig_evt;
  logic seq_idle;
  logic start_evt;
  logic set_fin;
  logic nap_load;
  logic nap_expire;

  sense_seq_trigger u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_sel (trig_sel),
    .host_go  (host_go),
    .ext_trig (ext_trig),
    .trig_evt (trig_evt)
  );

  sense_seq_nap_timer #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .MS_W         (MS_W)
  ) u_nap (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (nap_load),
    .ms_val (nap_ms(nap_code)),
    .run    (state == ST_NAP),
    .expire (nap_expire)
  );

  assign plan_now  = plan_of(chan_code, temp_en);
  assign seq_idle  = (state == ST_IDLE);
  assign start_evt = seq_idle && (((pwr_mode == MODE_STBY) && trig_evt) ||
                                  (pwr_mode == MODE_CONT) || (pwr_mode == MODE_NAP));
  assign set_fin   = (state == ST_STEP) && (idx == plan_q.n);
  assign nap_load  = set_fin && (pwr_mode == MODE_NAP);

  assign conv_start   = (state == ST_STEP) && (idx != plan_q.n);
  assign conv_chan    = plan_q.ch[idx[1:0]];
  assign conv_samples = samples_of(avg_code);
  assign busy         = (state == ST_STEP) || (state == ST_WAIT);
  assign set_done     = set_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      plan_q       <= '0;
      idx          <= '0;
      set_count    <= '0;
      result_ready <= 1'b0;
      set_done_q   <= 1'b0;
    end else begin
      set_done_q <= 1'b0;
      if (rd_ack) result_ready <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_evt) begin
            plan_q       <= plan_now;
            idx          <= '0;
            result_ready <= 1'b0;
            state        <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (set_fin) begin
            set_done_q   <= 1'b1;
            set_count    <= set_count + SET_CNT_W'(1);
            result_ready <= 1'b1;
            state        <= (pwr_mode == MODE_NAP) ? ST_NAP : ST_IDLE;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (conv_done) begin
            idx   <= idx + 3'd1;
            state <= ST_STEP;
          end
        end
        ST_NAP: begin
          if ((pwr_mode != MODE_NAP) || nap_expire) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sense_seq_chk.sv
module sense_seq_chk #(
  parameter int SET_CNT_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           pwr_mode,
  input logic                 conv_start,
  input logic                 set_done,
  input logic [SET_CNT_W-1:0] set_count,
  input logic                 result_ready,
  input logic                 seq_idle,
  input logic                 start_evt
);
  // R12: one-cycle pulses
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> !set_done);
  a_r12_start_gap: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R9: counter advances only with completion
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |-> set_count == $past(set_count) + SET_CNT_W'(1));
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_done |-> $stable(set_count));

  // R10: ready rises only with completion, and is high at completion
  a_r10_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_ready) |-> set_done);
  a_r10_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |-> result_ready);

  // R6: idle in sleep never starts a conversion
  a_r6_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && pwr_mode == 2'd1) |=> !conv_start);

  // R3: an accepted start leads at once to a conversion or an empty-set finish path
  a_r3_start_progress: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (conv_start || !seq_idle));
endmodule

bind sense_seq_top sense_seq_chk #(.SET_CNT_W(SET_CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_mode     (pwr_mode),
  .conv_start   (conv_start),
  .set_done     (set_done),
  .set_count    (set_count),
  .result_ready (result_ready),
  .seq_idle     (seq_idle),
  .start_evt    (start_evt)
);

// File: tb/sense_seq_top_bench.sv
module sense_seq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwr_mode = 2'd0;
  logic       trig_sel = 1'b0;
  logic [3:0] chan_code = 4'd0;
  logic       temp_en = 1'b0;
  logic [2:0] avg_code = 3'd0;
  logic [3:0] nap_code = 4'd0;
  logic       host_go = 1'b0;
  logic       ext_trig = 1'b0;
  logic       conv_done;
  logic       rd_ack = 1'b0;
  logic       conv_start;
  logic [1:0] conv_chan;
  logic [5:0] conv_samples;
  logic       busy;
  logic [2:0] set_count;
  logic       result_ready;
  logic       set_done;

  int vectors = 0;
  int fails   = 0;
  bit ended   = 0;

  sense_seq_top #(.TICKS_PER_MS(TICKS), .SET_CNT_W(3)) u_sense_seq_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Converter stub: latency of two cycles per averaged sample
  int lat_cnt = 0;
  int chan_log [0:7];
  int nlog = 0;
  int nstart = 0;
  int ndone = 0;

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (set_done) ndone <= ndone + 1;
    if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) conv_done <= 1'b1;
    end else if (conv_start) begin
      lat_cnt <= 2 * int'(conv_samples);
      nstart  <= nstart + 1;
      if (nlog < 8) chan_log[nlog] <= int'(conv_chan);
      nlog <= nlog + 1;
    end
  end
  initial conv_done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int k;
    k = 0;
    while (!set_done && k < 3000) begin
      @(negedge clk);
      k++;
    end
    if (!set_done) chk(1'b0, req, 0, 1);
  endtask

  task automatic pulse_host();
    host_go = 1'b1;
    tick(1);
    host_go = 1'b0;
  endtask

  task automatic t_reset();
    chk(conv_start == 1'b0 && busy == 1'b0, "R1 start/busy", int'(conv_start), 0);
    chk(set_count == 3'd0, "R1 set_count", int'(set_count), 0);
    chk(result_ready == 1'b0 && set_done == 1'b0, "R1 ready/done", int'(result_ready), 0);
  endtask

  task automatic t_order(input logic [3:0] code, input logic ten, input int exp_n, input int exp_seq);
    int packed_act;
    pwr_mode = 2'd0; trig_sel = 1'b0; chan_code = code; temp_en = ten; avg_code = 3'd0;
    tick(1);
    nlog = 0;
    pulse_host();
    wait_done("R2 order timeout");
    packed_act = 0;
    for (int i = 0; i < nlog && i < 8; i++) packed_act = (packed_act << 4) | chan_log[i];
    chk(nlog == exp_n, "R2 channel count", nlog, exp_n);
    chk(packed_act == exp_seq, "R2 channel order", packed_act, exp_seq);
    tick(2);
  endtask

  task automatic t_empty();
    int s0;
    pwr_mode = 2'd0; trig_sel = 1'b0; chan_code = 4'd0; temp_en = 1'b0;
    tick(1);
    s0 = nstart;
    host_go = 1'b1;
    tick(1);
    host_go = 1'b0;
    tick(1);
    chk(set_done == 1'b1, "R3 empty set done at +2", int'(set_done), 1);
    tick(1);
    chk(set_done == 1'b0, "R12 done one cycle", int'(set_done), 0);
    chk(nstart == s0, "R3 empty set no start", nstart - s0, 0);
    // reserved code: temperature only
    t_order(4'hD, 1'b1, 1, 'h0);
  endtask

  task automatic t_ext();
    int d0;
    pwr_mode = 2'd0; trig_sel = 1'b1; chan_code = 4'd1; temp_en = 1'b0;
    tick(2);
    d0 = ndone;
    pulse_host();
    tick(12);
    chk(ndone == d0, "R4 host ignored when pin selected", ndone - d0, 0);
    ext_trig = 1'b1;
    tick(1);
    chk(conv_start == 1'b1, "R4 pin edge starts next cycle", int'(conv_start), 1);
    wait_done("R4 pin set timeout");
    tick(25);
    chk(ndone == d0 + 1, "R4 level does not retrigger", ndone - d0, 1);
    ext_trig = 1'b0;
    trig_sel = 1'b0;
    tick(2);
    d0 = ndone;
    ext_trig = 1'b1;
    tick(12);
    chk(ndone == d0, "R4 pin ignored when host selected", ndone - d0, 0);
    ext_trig = 1'b0;
    tick(2);
  endtask

  task automatic t_drop();
    int d0, s0;
    pwr_mode = 2'd0; trig_sel = 1'b0; chan_code = 4'd7; temp_en = 1'b0; avg_code = 3'd2;
    tick(1);
    d0 = ndone; s0 = nstart;
    pulse_host();
    tick(3);
    pulse_host();
    tick(10);
    pulse_host();
    tick(5);
    pulse_host();
    wait_done("R5 set timeout");
    tick(60);
    chk(ndone == d0 + 1, "R5 one set despite triggers", ndone - d0, 1);
    chk(nstart == s0 + 3, "R5 start count", nstart - s0, 3);
    avg_code = 3'd0;
  endtask

  task automatic t_sleep();
    int s0;
    pwr_mode = 2'd1; chan_code = 4'd7;
    tick(1);
    s0 = nstart;
    pulse_host();
    tick(5);
    pulse_host();
    tick(40);
    chk(nstart == s0, "R6 sleep no conversions", nstart - s0, 0);
  endtask

  task automatic t_cont();
    int s0;
    chan_code = 4'd1; temp_en = 1'b0; avg_code = 3'd0;
    pwr_mode = 2'd2;
    wait_done("R7 first set timeout");
    tick(1);
    chk(conv_start == 1'b1, "R7 back-to-back start", int'(conv_start), 1);
    pwr_mode = 2'd1;
    wait_done("R6 running set finishes");
    chk(set_done == 1'b1, "R6 running set finishes", int'(set_done), 1);
    tick(1);
    s0 = nstart;
    tick(30);
    chk(nstart == s0, "R6 no new set after sleep", nstart - s0, 0);
  endtask

  task automatic t_nap();
    int k;
    chan_code = 4'd1; temp_en = 1'b0; avg_code = 3'd0; nap_code = 4'd0;
    pwr_mode = 2'd3;
    tick(1);
    chk(conv_start == 1'b1, "R8 first set at once", int'(conv_start), 1);
    wait_done("R8 set timeout");
    k = 0;
    while (!conv_start && k < 500) begin tick(1); k++; end
    chk(k == 1 * TICKS + 1, "R8 nap code 0", k, 1 * TICKS + 1);
    nap_code = 4'd1;
    wait_done("R8 set timeout");
    k = 0;
    while (!conv_start && k < 500) begin tick(1); k++; end
    chk(k == 5 * TICKS + 1, "R8 nap code 1", k, 5 * TICKS + 1);
    nap_code = 4'd2;
    wait_done("R8 set timeout");
    k = 0;
    while (!conv_start && k < 500) begin tick(1); k++; end
    chk(k == 10 * TICKS + 1, "R8 nap code 2", k, 10 * TICKS + 1);
    pwr_mode = 2'd0;
    wait_done("R8 last set");
    tick(3);
  endtask

  task automatic t_wrap();
    int c0;
    pwr_mode = 2'd0; trig_sel = 1'b0; chan_code = 4'd0; temp_en = 1'b0;
    tick(1);
    c0 = int'(set_count);
    for (int i = 1; i <= 9; i++) begin
      pulse_host();
      tick(2);
      chk(int'(set_count) == ((c0 + i) % 8), "R9 counter wrap", int'(set_count), (c0 + i) % 8);
    end
  endtask

  task automatic t_ready();
    pwr_mode = 2'd0; trig_sel = 1'b0; chan_code = 4'd7; temp_en = 1'b1;
    tick(1);
    pulse_host();
    chk(result_ready == 1'b0, "R10 cleared at start", int'(result_ready), 0);
    wait_done("R10 set timeout");
    chk(result_ready == 1'b1, "R10 set with done", int'(result_ready), 1);
    tick(2);
    rd_ack = 1'b1;
    tick(1);
    rd_ack = 1'b0;
    chk(result_ready == 1'b0, "R10 ack clears", int'(result_ready), 0);
    chan_code = 4'd0; temp_en = 1'b0;
    host_go = 1'b1;
    tick(1);
    host_go = 1'b0;
    rd_ack = 1'b1;
    tick(1);
    rd_ack = 1'b0;
    chk(set_done == 1'b1 && result_ready == 1'b1, "R10 completion beats ack", int'(result_ready), 1);
    tick(2);
  endtask

  task automatic t_samples();
    int e;
    for (int c = 0; c < 8; c++) begin
      avg_code = 3'(c);
      #1;
      e = (c > 5) ? 32 : (1 << c);
      chk(int'(conv_samples) == e, "R11 samples", int'(conv_samples), e);
    end
    avg_code = 3'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_samples();
    t_order(4'h7, 1'b1, 4, 'h0123);
    t_order(4'h8, 1'b0, 3, 'h121);
    t_order(4'h9, 1'b0, 3, 'h212);
    t_order(4'hA, 1'b0, 3, 'h232);
    t_order(4'hB, 1'b1, 4, 'h0131);
    t_order(4'h5, 1'b0, 2, 'h31);
    t_order(4'h6, 1'b0, 2, 'h23);
    t_order(4'h3, 1'b0, 2, 'h12);
    t_empty();
    t_ext();
    t_drop();
    t_sleep();
    t_cont();
    t_nap();
    t_wrap();
    t_ready();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule